// File: doc/BRIEF.md
# PWM Trip Latch Controller

This block holds the protection state for a pair of PWM outputs, A and B, and overrides those outputs while a trip is held. Each output has its own trip event. The event is taken either from a raw comparator path or from a filtered or delayed path that is built elsewhere. The event can enter the controller combinationally, or after a synchroniser clocked by the PWM time base. Each event is then routed to one of two latches. The first is a one-shot latch that only a software clear command can release. The second is a cycle-by-cycle latch that releases by itself at the next PWM period boundary.

While either latch is set, every output applies its own 2-bit action code. The code can drive the output to high impedance, force it high, force it low, or let the raw PWM pass. Per-source cause flags record which event tripped. Clearing a cause flag is a reporting action only and never releases an output. An interrupt is raised whenever a latch goes from clear to set, and it stays pending until software clears it. Index 0 of every paired vector belongs to output A and index 1 belongs to output B.

Top module: `pwm_trip_latch`

## Requirements
- R1: After reset both latches, both cause flags and the interrupt are 0, pwm_oe is 2'b11, ovr_en is 2'b00, and each output follows its raw PWM input.
- R2: While either latch is set, each output applies its own action code independently: 0 drives the output to high impedance (pwm_oe bit 0, output 0), 1 forces it to 1, 2 forces it to 0, and 3 passes the raw PWM. The ovr_en bit of an output is 1 only when a latch is set and that output's code is not 3.
- R3: On the raw path an output's event is asserted when its high-side compare input cmp_hi is 0.
- R4: When src_sel bit i is 1, event i comes from filt_evt bit i and cmp_hi bit i is ignored. When src_sel bit i is 0, the raw path is used.
- R5: When async_sel bit i is 1, an event present before a clock edge sets its latch at that edge. When async_sel bit i is 0, the event passes through SYNC_STAGES flops first (default 2), so the latch sets at the third edge.
- R6: Route code per event: 1 sends the event to the cycle-by-cycle latch, 2 sends it to the one-shot latch, and 0 or 3 discards the event, which then sets no latch, cause flag or interrupt.
- R7: The cycle-by-cycle latch clears at an edge where prd_strobe is 1, unless a routed cycle-by-cycle event is present in that same cycle; in that case it stays set.
- R8: The one-shot latch stays set until clr_osht is asserted. Clearing it releases both outputs.
- R9: cause_flag bit i is set when event i reaches a latch. clr_cause bit i clears only that bit and leaves both latches and both outputs unchanged.
- R10: irq sets when either latch goes from 0 to 1 and stays 1 until clr_irq.
- R11: When a trip arrives in the same cycle as its clear command (clr_osht, clr_cause or clr_irq), the trip wins and the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_a_in | input | 1 | Raw PWM for output A |
| pwm_b_in | input | 1 | Raw PWM for output B |
| cmp_hi | input | 2 | High-side compare inputs, active low |
| filt_evt | input | 2 | Filtered or delayed events, active high |
| src_sel | input | 2 | 1 selects the filtered event |
| async_sel | input | 2 | 1 bypasses the synchroniser |
| route_a | input | 2 | Latch routing code for event A |
| route_b | input | 2 | Latch routing code for event B |
| act_a | input | 2 | Action code for output A |
| act_b | input | 2 | Action code for output B |
| prd_strobe | input | 1 | One-cycle PWM period boundary strobe |
| clr_osht | input | 1 | Global one-shot clear command |
| clr_irq | input | 1 | Interrupt clear command |
| clr_cause | input | 2 | Per-source cause flag clears |
| pwm_a_out | output | 1 | Gated PWM A |
| pwm_b_out | output | 1 | Gated PWM B |
| pwm_oe | output | 2 | Output enables; 0 means high impedance |
| ovr_en | output | 2 | Override active per output |
| osht_flag | output | 1 | One-shot latch state |
| cbc_flag | output | 1 | Cycle-by-cycle latch state |
| cause_flag | output | 2 | Trip cause per source |
| irq | output | 1 | Pending trip interrupt |

## Verification
A trip and a release can land on the same edge. A new event can coincide with clr_osht, with clr_cause or with clr_irq. A continuing cycle-by-cycle event can coincide with the period strobe. The bench drives each of these pairs in one cycle on purpose. After that edge it reads the flag, the cause bit and the interrupt, and expects the set side to have won. It then drops the event, repeats the release alone, and confirms that the release now takes effect. This shows the trip had priority and the release was not simply broken.

// File: rtl/trip_pkg.sv
package trip_pkg;
   typedef enum logic [1:0] {
      ACT_HIZ  = 2'd0,
      ACT_HIGH = 2'd1,
      ACT_LOW  = 2'd2,
      ACT_KEEP = 2'd3
   } act_e;

   typedef enum logic [1:0] {
      RT_NONE  = 2'd0,
      RT_CBC   = 2'd1,
      RT_OSHT  = 2'd2,
      RT_NONE2 = 2'd3
   } route_e;
endpackage

// File: rtl/trip_evt_path.sv
module trip_evt_path #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmp_hi,
   input  logic filt_evt,
   input  logic src_sel,
   input  logic async_sel,
   output logic evt
);
   logic                   picked;
   logic [SYNC_STAGES-1:0] sync_q;

   // raw path: high-side compare low means trip; filtered path is active high
   assign picked = src_sel ? filt_evt : ~cmp_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
      end else begin
         sync_q[0] <= picked;
         for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      end
   end

   assign evt = async_sel ? picked : sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/trip_latch_core.sv
module trip_latch_core
   import trip_pkg::*;
#(
   parameter int NCH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCH-1:0]   evt,
   input  logic [2*NCH-1:0] route,
   input  logic             prd_strobe,
   input  logic             clr_osht,
   input  logic             clr_irq,
   input  logic [NCH-1:0]   clr_cause,
   output logic             osht_q,
   output logic             cbc_q,
   output logic             irq_q,
   output logic [NCH-1:0]   cause_q,
   output logic             osht_hit,
   output logic             cbc_hit
);
   logic [NCH-1:0] to_osht, to_cbc;
   logic           set_pulse;

   for (genvar i = 0; i < NCH; i++) begin : g_route
      route_e rt;
      assign rt         = route_e'(route[2*i +: 2]);
      assign to_osht[i] = evt[i] && (rt == RT_OSHT);
      assign to_cbc[i]  = evt[i] && (rt == RT_CBC);
   end

   assign osht_hit  = |to_osht;
   assign cbc_hit   = |to_cbc;
   assign set_pulse = (osht_hit && !osht_q) || (cbc_hit && !cbc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         osht_q  <= 1'b0;
         cbc_q   <= 1'b0;
         irq_q   <= 1'b0;
         cause_q <= '0;
      end else begin
         osht_q  <= osht_hit  || (osht_q && !clr_osht);
         cbc_q   <= cbc_hit   || (cbc_q  && !prd_strobe);
         irq_q   <= set_pulse || (irq_q  && !clr_irq);
         cause_q <= (to_osht | to_cbc) | (cause_q & ~clr_cause);
      end
   end
endmodule

// File: rtl/trip_out_gate.sv
module trip_out_gate
   import trip_pkg::*;
(
   input  logic       raw,
   input  logic       active,
   input  logic [1:0] act,
   output logic       out,
   output logic       oe,
   output logic       ovr
);
   act_e code;
   assign code = act_e'(act);

   always_comb begin
      out = raw;
      oe  = 1'b1;
      ovr = 1'b0;
      if (active) begin
         unique case (code)
            ACT_HIZ:  begin out = 1'b0; oe = 1'b0; ovr = 1'b1; end
            ACT_HIGH: begin out = 1'b1; ovr = 1'b1; end
            ACT_LOW:  begin out = 1'b0; ovr = 1'b1; end
            default:  out = raw;
         endcase
      end
   end
endmodule

// File: rtl/pwm_trip_latch.sv
module pwm_trip_latch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwm_a_in,
   input  logic       pwm_b_in,
   input  logic [1:0] cmp_hi,
   input  logic [1:0] filt_evt,
   input  logic [1:0] src_sel,
   input  logic [1:0] async_sel,
   input  logic [1:0] route_a,
   input  logic [1:0] route_b,
   input  logic [1:0] act_a,
   input  logic [1:0] act_b,
   input  logic       prd_strobe,
   input  logic       clr_osht,
   input  logic       clr_irq,
   input  logic [1:0] clr_cause,
   output logic       pwm_a_out,
   output logic       pwm_b_out,
   output logic [1:0] pwm_oe,
   output logic [1:0] ovr_en,
   output logic       osht_flag,
   output logic       cbc_flag,
   output logic [1:0] cause_flag,
   output logic       irq
);
   localparam int NCH = 2;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 8) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..8");
   end

   logic [NCH-1:0]   evt;
   logic [2*NCH-1:0] route;
   logic [NCH-1:0]   raw_pwm, gated, oe_v, ovr_v;
   logic [2*NCH-1:0] act;
   logic             osht_hit, cbc_hit, trip_active;

   assign route   = {route_b, route_a};
   assign act     = {act_b, act_a};
   assign raw_pwm = {pwm_b_in, pwm_a_in};

   for (genvar i = 0; i < NCH; i++) begin : g_path
      trip_evt_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmp_hi    (cmp_hi[i]),
         .filt_evt  (filt_evt[i]),
         .src_sel   (src_sel[i]),
         .async_sel (async_sel[i]),
         .evt       (evt[i])
      );
   end

   trip_latch_core #(.NCH(NCH)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        (evt),
      .route      (route),
      .prd_strobe (prd_strobe),
      .clr_osht   (clr_osht),
      .clr_irq    (clr_irq),
      .clr_cause  (clr_cause),
      .osht_q     (osht_flag),
      .cbc_q      (cbc_flag),
      .irq_q      (irq),
      .cause_q    (cause_flag),
      .osht_hit   (osht_hit),
      .cbc_hit    (cbc_hit)
   );

   assign trip_active = osht_flag || cbc_flag;

   for (genvar i = 0; i < NCH; i++) begin : g_gate
      trip_out_gate u_gate (
         .raw    (raw_pwm[i]),
         .active (trip_active),
         .act    (act[2*i +: 2]),
         .out    (gated[i]),
         .oe     (oe_v[i]),
         .ovr    (ovr_v[i])
      );
   end

   assign pwm_a_out = gated[0];
   assign pwm_b_out = gated[1];
   assign pwm_oe    = oe_v;
   assign ovr_en    = ovr_v;
endmodule

// File: rtl/pwm_trip_latch_chk.sv
module pwm_trip_latch_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       osht_flag,
   input logic       cbc_flag,
   input logic       irq,
   input logic       clr_osht,
   input logic       clr_irq,
   input logic       prd_strobe,
   input logic       osht_hit,
   input logic       cbc_hit,
   input logic [1:0] act_a,
   input logic       pwm_a_out,
   input logic [1:0] pwm_oe,
   input logic [1:0] cause_flag,
   input logic [1:0] clr_cause
);
   // R8
   osht_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osht_flag && !clr_osht |=> osht_flag);

   // R11
   trip_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      osht_hit |=> osht_flag);

   // R7
   cbc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cbc_flag && prd_strobe && !cbc_hit |=> !cbc_flag);

   // R10
   irq_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osht_flag) || $rose(cbc_flag) |-> irq);

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr_irq |=> irq);

   // R2
   force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (osht_flag || cbc_flag) && act_a == 2'd2 |-> pwm_oe[0] && !pwm_a_out);

   // R9
   cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_flag[0] && !clr_cause[0] |=> cause_flag[0]);
endmodule

bind pwm_trip_latch pwm_trip_latch_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .osht_flag  (osht_flag),
   .cbc_flag   (cbc_flag),
   .irq        (irq),
   .clr_osht   (clr_osht),
   .clr_irq    (clr_irq),
   .prd_strobe (prd_strobe),
   .osht_hit   (osht_hit),
   .cbc_hit    (cbc_hit),
   .act_a      (act_a),
   .pwm_a_out  (pwm_a_out),
   .pwm_oe     (pwm_oe),
   .cause_flag (cause_flag),
   .clr_cause  (clr_cause)
);

// File: tb/tb_pwm_trip_latch.sv
module tb_pwm_trip_latch;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_a_in = 1'b0, pwm_b_in = 1'b0;
   logic [1:0] cmp_hi = 2'b11, filt_evt = 2'b00, src_sel = 2'b00, async_sel = 2'b11;
   logic [1:0] route_a = 2'd0, route_b = 2'd0, act_a = 2'd2, act_b = 2'd2;
   logic prd_strobe = 1'b0, clr_osht = 1'b0, clr_irq = 1'b0;
   logic [1:0] clr_cause = 2'b00;
   logic pwm_a_out, pwm_b_out, osht_flag, cbc_flag, irq;
   logic [1:0] pwm_oe, ovr_en, cause_flag;
   int tests = 0, fails = 0;

   always #2 clk = ~clk;

   pwm_trip_latch dut (.*);

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic clear_all();
      cmp_hi = 2'b11; filt_evt = 2'b00;
      clr_osht = 1'b1; clr_irq = 1'b1; clr_cause = 2'b11; prd_strobe = 1'b1;
      tick(1);
      clr_osht = 1'b0; clr_irq = 1'b0; clr_cause = 2'b00; prd_strobe = 1'b0;
   endtask

   task automatic t_reset();
      pwm_a_in = 1'b1; pwm_b_in = 1'b0; #1;
      chk("R1 flags", {osht_flag, cbc_flag, irq, cause_flag}, 8'h00);
      chk("R1 oe/ovr", {pwm_oe, ovr_en}, 8'b1100);
      chk("R1 pass", {pwm_a_out, pwm_b_out}, 8'b10);
   endtask

   task automatic t_oneshot();
      route_a = 2'd2; act_a = 2'd2; act_b = 2'd1;
      cmp_hi = 2'b10; tick(1); cmp_hi = 2'b11;
      chk("R8 set", osht_flag, 1);
      chk("R2 outs", {pwm_a_out, pwm_b_out, ovr_en}, 8'b0111);
      chk("R10 irq", irq, 1);
      chk("R9 cause", cause_flag, 2'b01);
      tick(3);
      chk("R8 hold", osht_flag, 1);
      clr_cause = 2'b01; tick(1); clr_cause = 2'b00;
      chk("R9 cleared", cause_flag, 0);
      chk("R9 no release", {osht_flag, pwm_a_out}, 8'b10);
      clr_osht = 1'b1; tick(1); clr_osht = 1'b0;
      chk("R8 release", {osht_flag, pwm_a_out, pwm_b_out, ovr_en}, 8'b01000);
      chk("R10 pending", irq, 1);
      clr_irq = 1'b1; tick(1); clr_irq = 1'b0;
      chk("R10 clr", irq, 0);
   endtask

   task automatic t_actions();
      act_a = 2'd0; act_b = 2'd3; pwm_b_in = 1'b0;
      cmp_hi = 2'b10; tick(1); cmp_hi = 2'b11;
      chk("R2 hiz/keep", {pwm_oe, pwm_a_out, pwm_b_out}, 8'b1000);
      pwm_b_in = 1'b1; #1;
      chk("R2 keep raw", {pwm_b_out, ovr_en}, 8'b101);
      clear_all();
      act_a = 2'd2; act_b = 2'd2;
   endtask

   task automatic t_source();
      route_a = 2'd0; route_b = 2'd2; src_sel = 2'b10;
      cmp_hi = 2'b01; tick(1);
      chk("R4 raw ignored", {osht_flag, cause_flag}, 8'h0);
      cmp_hi = 2'b11; filt_evt = 2'b10; tick(1); filt_evt = 2'b00;
      chk("R4 filt", {osht_flag, cause_flag}, 8'b110);
      clear_all();
      src_sel = 2'b00; cmp_hi = 2'b01; tick(1); cmp_hi = 2'b11;
      chk("R3 hi low", osht_flag, 1);
      clear_all();
      route_b = 2'd0;
   endtask

   task automatic t_sync();
      async_sel = 2'b00; route_a = 2'd2;
      cmp_hi = 2'b10; tick(1); cmp_hi = 2'b11;
      chk("R5 edge1", osht_flag, 0);
      tick(1);
      chk("R5 edge2", osht_flag, 0);
      tick(1);
      chk("R5 edge3", osht_flag, 1);
      tick(2);
      clear_all();
      async_sel = 2'b11;
   endtask

   task automatic t_cbc();
      route_a = 2'd1;
      cmp_hi = 2'b10; tick(1); cmp_hi = 2'b11;
      chk("R7 set", {cbc_flag, osht_flag, pwm_a_out}, 8'b100);
      tick(2);
      chk("R7 hold", cbc_flag, 1);
      prd_strobe = 1'b1; tick(1); prd_strobe = 1'b0;
      chk("R7 release", {cbc_flag, ovr_en}, 8'b000);
      cmp_hi = 2'b10; tick(1);
      prd_strobe = 1'b1; tick(1); prd_strobe = 1'b0;
      chk("R7 relatch", cbc_flag, 1);
      cmp_hi = 2'b11; prd_strobe = 1'b1; tick(1); prd_strobe = 1'b0;
      chk("R7 final", cbc_flag, 0);
      clear_all();
   endtask

   task automatic t_route_off();
      route_a = 2'd3; route_b = 2'd0;
      cmp_hi = 2'b00; tick(2); cmp_hi = 2'b11;
      chk("R6 off", {osht_flag, cbc_flag, irq, cause_flag}, 8'h0);
      chk("R6 outs", {pwm_oe, ovr_en}, 8'b1100);
   endtask

   task automatic t_race();
      route_a = 2'd2;
      cmp_hi = 2'b10; tick(1);
      clr_osht = 1'b1; clr_cause = 2'b01; tick(1);
      clr_osht = 1'b0; clr_cause = 2'b00;
      chk("R11 osht", osht_flag, 1);
      chk("R11 cause", cause_flag, 2'b01);
      cmp_hi = 2'b11; clr_osht = 1'b1; tick(1); clr_osht = 1'b0;
      chk("R11 later clear", osht_flag, 0);
      cmp_hi = 2'b10; clr_irq = 1'b1; tick(1);
      clr_irq = 1'b0; cmp_hi = 2'b11;
      chk("R11 irq", {irq, osht_flag}, 8'b11);
      clear_all();
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      tick(3);
      t_reset();
      rst_n = 1'b1;
      tick(1);
      t_oneshot();
      t_actions();
      t_source();
      t_sync();
      t_cbc();
      t_route_off();
      t_race();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule